// File: doc/BRIEF.md
# Cache-Line Burst Fill Sequencer

This block refills one cache line after a miss in the last-level cache. It takes a miss request carrying an address and clears the offset bits of that address so it points at the start of a line. It puts that line address on the memory bus for a single cycle. It then waits out a fixed device access time and gathers a run of 64-bit data beats into a line buffer. When the final beat is stored, it raises a one-cycle completion pulse and presents the whole line together with its address.

The memory behind the bus is a set of byte-wide synchronous DRAM devices. Each device owns one byte lane of every beat. The sequencer puts the lanes back together so that beat k, lane j lands in line byte 8k+j. The line size, bus width and access latency are parameters, and the beat count is their quotient.

With the default settings (128-byte line, 8-byte bus, 4-cycle access) a fill takes 1 address cycle, 4 access cycles and 16 data beats. That makes 21 bus cycles from acceptance to completion. New misses are taken only while the sequencer is idle. A request made during a fill is held off by the ready signal.

Top module: `line_fill_seq`

## Requirements
- R1: After reset is released, req_ready is 1, while fill_done and mem_addr_valid are 0.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. mem_addr_valid is then 1 for exactly one cycle, the cycle that directly follows that edge.
- R3: mem_addr and fill_addr carry the request address with its low log2(LINE_BYTES) bits forced to zero. With the defaults, these are bits [6:0].
- R4: req_ready is 0 from the acceptance edge until the completion cycle has ended. A request presented in that time is not taken, and it does not change fill_addr.
- R5: The data beat taken k-th in a fill is stored in fill_line bits [64k+63:64k]. Byte lane j of that beat (mem_data bits [8j+7:8j]) becomes line byte 8k+j, which is fill_line bits [64k+8j+7:64k+8j].
- R6: fill_done is a one-cycle pulse. It is high in the cycle that starts 1 + ACCESS_LAT + BEATS clock edges after the acceptance edge. With the defaults that is 21 edges.
- R7: While fill_done is 1, fill_addr equals the line address of the request that started the fill.
- R8: mem_data_valid has no effect outside the data window: during the address and access cycles, and while idle, fill_line does not change.
- R9: req_ready returns to 1 in the cycle right after the completion pulse, so a new miss can be accepted on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| req_valid | input | 1 | Miss request present |
| req_addr | input | ADDR_W | Miss address; offset bits are ignored |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| mem_addr_valid | output | 1 | Address cycle on the memory bus |
| mem_addr | output | ADDR_W | Line address toward memory |
| mem_data_valid | input | 1 | Data beat present on mem_data |
| mem_data | input | BUS_BYTES*8 | One beat, one byte lane per device |
| fill_done | output | 1 | One-cycle line completion pulse |
| fill_addr | output | ADDR_W | Line address of the completed fill |
| fill_line | output | LINE_BYTES*8 | Reassembled cache line |

## Verification
Each result has a fixed due cycle, counted from the acceptance edge. The address cycle is due one edge after acceptance. The first data beat is due 1 + ACCESS_LAT edges after acceptance. The completion pulse, the address and the full line are due at 1 + ACCESS_LAT + BEATS edges, and ready is due one edge after that. The bench acts as the memory and drives beats on falling edges at exactly those offsets. It samples every output on the falling edge inside the cycle where the result is due. It also checks that fill_done is still 0 one cycle before that and 0 again one cycle after, so a result that arrives one cycle early or late is caught.

// File: rtl/line_fill_pkg.sv
package line_fill_pkg;

  // Sequencer phases of one line fill
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_ADDR,
    FS_WAIT,
    FS_DATA,
    FS_DONE
  } fill_state_e;

endpackage

// File: rtl/fill_rst_sync.sv
module fill_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/fill_ctrl.sv
module fill_ctrl
  import line_fill_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int BEATS      = 16,
  parameter int ACCESS_LAT = 4,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int LAT_W     = $clog2(ACCESS_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              mem_addr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_data_valid,
  output logic              beat_we,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              fill_done,
  output logic [ADDR_W-1:0] fill_addr
);

  localparam logic [ADDR_W-1:0] OFF_MASK  = ADDR_W'(LINE_BYTES - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [LAT_W-1:0]  LAST_WAIT = LAT_W'(ACCESS_LAT - 1);

  fill_state_e       state_q, state_d;
  logic [LAT_W-1:0]  lat_q, lat_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [ADDR_W-1:0] addr_q;
  logic              accept;
  logic              cnt_en;

  assign accept = req_valid && (state_q == FS_IDLE);

  // next-state process
  always_comb begin
    state_d = state_q;
    lat_d   = lat_q;
    beat_d  = beat_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      FS_IDLE: begin
        if (req_valid) state_d = FS_ADDR;
      end
      FS_ADDR: begin
        state_d = FS_WAIT;
        lat_d   = '0;
        cnt_en  = 1'b1;
      end
      FS_WAIT: begin
        cnt_en = 1'b1;
        if (lat_q == LAST_WAIT) begin
          state_d = FS_DATA;
          beat_d  = '0;
        end else begin
          lat_d = lat_q + 1'b1;
        end
      end
      FS_DATA: begin
        if (mem_data_valid) begin
          cnt_en = 1'b1;
          if (beat_q == LAST_BEAT) begin
            state_d = FS_DONE;
          end else begin
            beat_d = beat_q + 1'b1;
          end
        end
      end
      FS_DONE: begin
        state_d = FS_IDLE;
      end
      default: begin
        state_d = FS_IDLE;
      end
    endcase
  end

  // register processes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      beat_q <= '0;
    end else if (cnt_en) begin
      lat_q  <= lat_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr & ~OFF_MASK;
    end
  end

  assign req_ready      = (state_q == FS_IDLE);
  assign mem_addr_valid = (state_q == FS_ADDR);
  assign mem_addr       = addr_q;
  assign beat_we        = (state_q == FS_DATA) && mem_data_valid;
  assign beat_idx       = beat_q;
  assign fill_done      = (state_q == FS_DONE);
  assign fill_addr      = addr_q;

  assert_accept_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_addr_valid);

  assert_addr_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr_valid |=> !mem_addr_valid);

  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> !fill_done);

  assert_done_after_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_done) |-> $past(mem_data_valid));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(fill_addr));

  assert_ready_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> req_ready);

endmodule

// File: rtl/fill_line_buf.sv
module fill_line_buf #(
  parameter int BEATS     = 16,
  parameter int BUS_BYTES = 8,
  localparam int BEAT_W   = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BUS_W    = BUS_BYTES * 8,
  localparam int LINE_W   = BEATS * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_we,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic [BUS_W-1:0]  beat_data,
  output logic [LINE_W-1:0] line_o
);

  // one register per device byte lane of every beat slot
  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    logic slot_en;
    assign slot_en = beat_we && (beat_idx == BEAT_W'(b));
    for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          lane_q <= '0;
        end else if (slot_en) begin
          lane_q <= beat_data[l*8 +: 8];
        end
      end
      assign line_o[(b*BUS_BYTES + l)*8 +: 8] = lane_q;
    end
  end

  assert_lane_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    beat_we |=> (line_o[$past(beat_idx)*BUS_W +: BUS_W] == $past(beat_data)));

  assert_line_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_we |=> $stable(line_o));

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  parameter int BUS_BYTES  = 8,
  parameter int ACCESS_LAT = 4,
  localparam int BEATS     = LINE_BYTES / BUS_BYTES,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int BUS_W     = BUS_BYTES * 8,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              mem_addr_valid,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_data_valid,
  input  logic [BUS_W-1:0]  mem_data,
  output logic              fill_done,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_line
);

  logic              rst_n_s;
  logic              beat_we;
  logic [BEAT_W-1:0] beat_idx;

  fill_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  fill_ctrl #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BEATS      (BEATS),
    .ACCESS_LAT (ACCESS_LAT)
  ) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_s),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_ready      (req_ready),
    .mem_addr_valid (mem_addr_valid),
    .mem_addr       (mem_addr),
    .mem_data_valid (mem_data_valid),
    .beat_we        (beat_we),
    .beat_idx       (beat_idx),
    .fill_done      (fill_done),
    .fill_addr      (fill_addr)
  );

  fill_line_buf #(
    .BEATS     (BEATS),
    .BUS_BYTES (BUS_BYTES)
  ) i_buf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .beat_we   (beat_we),
    .beat_idx  (beat_idx),
    .beat_data (mem_data),
    .line_o    (fill_line)
  );

endmodule

// File: tb/test_line_fill_seq.sv
module test_line_fill_seq;

  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 128;
  localparam int BUS_BYTES  = 8;
  localparam int ACCESS_LAT = 4;
  localparam int BEATS      = LINE_BYTES / BUS_BYTES;
  localparam int BUS_W      = BUS_BYTES * 8;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int NVEC       = 6;

  // stimulus: request address, expected line address, stray-valid flag
  localparam logic [31:0] VEC_REQ [NVEC] = '{32'h0000_0000, 32'h0000_1234,
    32'hFFFF_FFFF, 32'h1234_5680, 32'h8000_007F, 32'h0BAD_C0DE};
  localparam logic [31:0] VEC_EXP [NVEC] = '{32'h0000_0000, 32'h0000_1200,
    32'hFFFF_FF80, 32'h1234_5680, 32'h8000_0000, 32'h0BAD_C080};
  localparam bit VEC_STRAY [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [ADDR_W-1:0] req_addr;
  logic              req_ready;
  logic              mem_addr_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_data_valid;
  logic [BUS_W-1:0]  mem_data;
  logic              fill_done;
  logic [ADDR_W-1:0] fill_addr;
  logic [LINE_W-1:0] fill_line;

  int tests = 0;
  int fails = 0;
  logic [LINE_W-1:0] last_line;

  line_fill_seq #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES),
    .BUS_BYTES  (BUS_BYTES),
    .ACCESS_LAT (ACCESS_LAT)
  ) i_line_fill_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_addr       (req_addr),
    .req_ready      (req_ready),
    .mem_addr_valid (mem_addr_valid),
    .mem_addr       (mem_addr),
    .mem_data_valid (mem_data_valid),
    .mem_data       (mem_data),
    .fill_done      (fill_done),
    .fill_addr      (fill_addr),
    .fill_line      (fill_line)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input logic [31:0] a, input int i);
    return 8'(a[14:7] * 8'd7 + 8'(i * 29) + a[22:15]);
  endfunction

  task automatic chk(input bit ok, input string rq,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic chk_line(input string rq, input logic [LINE_W-1:0] exp);
    int bad;
    bad = -1;
    for (int i = LINE_BYTES - 1; i >= 0; i--)
      if (fill_line[i*8 +: 8] !== exp[i*8 +: 8]) bad = i;
    if (bad < 0) chk(1'b1, rq, 64'd0, 64'd0);
    else chk(1'b0, {rq, " line byte"}, 64'(fill_line[bad*8 +: 8]), 64'(exp[bad*8 +: 8]));
  endtask

  // One fill: the bench acts as the memory responder with fixed timing.
  task automatic run_fill(input logic [31:0] a, input logic [31:0] ea, input bit stray);
    logic [LINE_W-1:0] exp_line;
    for (int i = 0; i < LINE_BYTES; i++) exp_line[i*8 +: 8] = pat(ea, i);
    req_addr  = a;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);                          // cycle after acceptance edge
    req_valid = stray;                       // busy request must be refused
    req_addr  = ~a;
    chk(mem_addr_valid == 1'b1, "R2 addr cycle", 64'(mem_addr_valid), 64'd1);
    chk(mem_addr == ea, "R3 mem_addr aligned", 64'(mem_addr), 64'(ea));
    chk(req_ready == 1'b0, "R4 ready low", 64'(req_ready), 64'd0);
    for (int w = 0; w < ACCESS_LAT; w++) begin
      @(negedge clk);
      mem_data_valid = stray;                // ignored during access wait (R8)
      mem_data       = {BUS_BYTES{8'hA5}};
      if (w == 0) chk(mem_addr_valid == 1'b0, "R2 single addr cycle", 64'(mem_addr_valid), 64'd0);
    end
    for (int k = 0; k < BEATS; k++) begin
      @(negedge clk);
      mem_data_valid = 1'b1;
      for (int j = 0; j < BUS_BYTES; j++) mem_data[j*8 +: 8] = pat(ea, k*BUS_BYTES + j);
      if (k == BEATS - 1) chk(fill_done == 1'b0, "R6 not early", 64'(fill_done), 64'd0);
    end
    @(negedge clk);                          // 1+LAT+BEATS edges after acceptance
    mem_data_valid = 1'b0;
    req_valid      = 1'b0;
    chk(fill_done == 1'b1, "R6 done due", 64'(fill_done), 64'd1);
    chk(fill_addr == ea, "R7 fill_addr", 64'(fill_addr), 64'(ea));
    chk(req_ready == 1'b0, "R4 ready low at done", 64'(req_ready), 64'd0);
    chk_line("R5 line", exp_line);
    chk(fill_line[(3*BUS_BYTES+5)*8 +: 8] == pat(ea, 29), "R5 beat3 lane5",
        64'(fill_line[(3*BUS_BYTES+5)*8 +: 8]), 64'(pat(ea, 29)));
    @(negedge clk);
    chk(fill_done == 1'b0, "R6 pulse width", 64'(fill_done), 64'd0);
    chk(req_ready == 1'b1, "R9 ready back", 64'(req_ready), 64'd1);
    last_line = exp_line;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n          = 1'b0;
    req_valid      = 1'b0;
    req_addr       = '0;
    mem_data_valid = 1'b0;
    mem_data       = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(fill_done == 1'b0, "R1 done after reset", 64'(fill_done), 64'd0);
    chk(mem_addr_valid == 1'b0, "R1 addr_valid after reset", 64'(mem_addr_valid), 64'd0);

    // vector table, back-to-back fills (R9)
    for (int v = 0; v < NVEC; v++) run_fill(VEC_REQ[v], VEC_EXP[v], VEC_STRAY[v]);

    // R8: stray beats while idle leave the line untouched
    for (int s = 0; s < 3; s++) begin
      mem_data_valid = 1'b1;
      mem_data       = {BUS_BYTES{8'h3C}} ^ BUS_W'(s);
      @(negedge clk);
    end
    mem_data_valid = 1'b0;
    @(negedge clk);
    chk_line("R8 idle beats ignored", last_line);
    chk(req_ready == 1'b1, "R8 still idle", 64'(req_ready), 64'd1);

    // idle gap then one more fill, then R4: busy address did not leak
    repeat (2) @(negedge clk);
    run_fill(32'h0000_00FF, 32'h0000_0080, 1'b1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule